// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs one clause-22 management transaction each time its 32-bit frame register is written. The frame register holds all fields of the transaction. The block derives the management clock MDC from the system clock. It first sends a run of ones as a preamble, then shifts the frame out on MDIO with the most significant bit first. For a read, it releases the line at the turnaround and shifts the sixteen bits the PHY returns into the low half of the same register.

The frame layout, from the most significant bit down, is: a 2-bit start code (written as 01), a 2-bit opcode (01 for write, 10 for read), a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround code (written as 10) and 16 bits of data. Software first sets the enable input and selects an MDC divisor to suit the system clock. It then writes the frame and polls the idle flag until the flag reads 1 again.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A frame write while idle with `mgmt_en_i` high starts a transaction. `idle_o` reads 0 from the next cycle for exactly 64 MDC periods (64 x divisor system cycles), then reads 1 again.
- R2: A transaction begins with 32 MDC periods in which MDIO is driven (`mdio_oe_o`=1) to 1.
- R3: After the preamble, frame bits 31 down to 0 are sent, one per MDC period, most significant first. When the opcode in bits 29:28 is not 10, all 32 bits are driven.
- R4: When the opcode is 10 (read), `mdio_oe_o` is 0 from frame bit 17 (the turnaround) through bit 0. The level on `mdio_i` at each MDC rising edge of bits 15..0 is shifted into `frame_o[15:0]`, first bit received ending in bit 15. Bits 31:16 keep their written value.
- R5: `clk_div_sel_i` values 0, 1, 2 and 3 select MDC periods of 8, 16, 32 and 64 system cycles. MDC is high for half the period and low for the other half. The selection is latched when a transaction starts.
- R6: During a transaction, `mdio_o` and `mdio_oe_o` change only in the cycle in which MDC falls.
- R7: A frame write while a transaction is in progress is ignored. It does not change `frame_o[31:16]` or the bits sent on the wire.
- R8: With `mgmt_en_i` low, a frame write loads `frame_o` but starts no transaction: `idle_o` stays 1 and `mdc_o` stays 0.
- R9: After reset, `frame_o` is 0, `idle_o` is 1, and `mdc_o` and `mdio_oe_o` are 0.
- R10: `mdc_o` is 0 whenever `idle_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mgmt_en_i | input | 1 | Management port enable |
| clk_div_sel_i | input | 2 | MDC divisor select (0:8, 1:16, 2:32, 3:64) |
| frame_we_i | input | 1 | Frame register write strobe |
| frame_wdata_i | input | 32 | Frame register write data |
| frame_o | output | 32 | Frame register contents, including read data |
| idle_o | output | 1 | 1 when no transaction is running |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output level |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input level |

## Verification
Writes and reads are each run with different frame contents and at all four divisors. Comparing written and read frames shows whether the read opcode alone releases the line from the turnaround and captures data. Running the divisor sweep finds errors in the period, the duty cycle or the latching of the selection. A write issued in the middle of a read separates ignored writes from accepted ones, and a write with the port disabled separates loading the register from starting a transaction. A PHY model returns a data pattern that is not symmetric, so a reversal of bit order or an off-by-one sample point shows up.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W   = 32;
  localparam int DATA_W    = 16;
  localparam int OP_HI     = 29;
  localparam int OP_LO     = 28;
  localparam int TA_HI     = 17;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef enum logic [1:0] {
    DIV_8  = 2'd0,
    DIV_16 = 2'd1,
    DIV_32 = 2'd2,
    DIV_64 = 2'd3
  } div_sel_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_BASE_LOG2 = 3,
  parameter int SEL_W         = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             run_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int N_SEL = 1 << SEL_W;
  localparam int CNT_W = DIV_BASE_LOG2 + N_SEL - 1;

  logic [CNT_W-1:0] lim_tbl  [N_SEL];
  logic [CNT_W-1:0] half_tbl [N_SEL];

  // divisor for select i is 2**(DIV_BASE_LOG2+i)
  for (genvar i = 0; i < N_SEL; i++) begin : g_div
    localparam int DIV = 1 << (DIV_BASE_LOG2 + i);
    assign lim_tbl[i]  = CNT_W'(DIV - 1);
    assign half_tbl[i] = CNT_W'(DIV / 2 - 1);
  end

  logic [CNT_W-1:0] cnt_q, lim_q, half_q;
  logic             mdc_q;

  assign rise_o = run_i && (cnt_q == half_q);
  assign fall_o = run_i && (cnt_q == lim_q);
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= lim_tbl[0];
      half_q <= half_tbl[0];
    end else if (load_i) begin
      lim_q  <= lim_tbl[sel_i];
      half_q <= half_tbl[sel_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + CNT_W'(1);
      if (rise_o)      mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq #(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16,
  parameter int TA_HI   = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               is_read_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic               sample_o
);
  localparam int TOTAL      = PRE_LEN + FRAME_W;
  localparam int IDX_W      = $clog2(TOTAL);
  localparam int LAST       = TOTAL - 1;
  localparam int DATA_FIRST = TOTAL - DATA_W;
  localparam int POS_W      = $clog2(FRAME_W);

  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             busy_q, out_q, oe_q;
  logic             nxt_d, nxt_oe;

  assign idx_nxt = idx_q + IDX_W'(1);

  // level and enable for wire bit idx_nxt
  always_comb begin
    int pos;
    pos    = LAST - int'(idx_nxt);
    nxt_d  = 1'b1;
    nxt_oe = 1'b1;
    if (int'(idx_nxt) >= PRE_LEN) begin
      nxt_d  = frame_i[POS_W'(pos)];
      nxt_oe = !(is_read_i && pos <= TA_HI);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      out_q  <= 1'b1;
      oe_q   <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        idx_q  <= '0;
        busy_q <= 1'b1;
        out_q  <= 1'b1;
        oe_q   <= 1'b1;
      end
    end else if (fall_i) begin
      if (int'(idx_q) == LAST) begin
        busy_q <= 1'b0;
        out_q  <= 1'b1;
        oe_q   <= 1'b0;
      end else begin
        idx_q <= idx_nxt;
        out_q <= nxt_d;
        oe_q  <= nxt_oe;
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;
  assign sample_o  = busy_q && rise_i && is_read_i && (int'(idx_q) >= DATA_FIRST);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN       = 32,
  parameter int DIV_BASE_LOG2 = 3,
  parameter int SEL_W         = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mgmt_en_i,
  input  logic [SEL_W-1:0]   clk_div_sel_i,
  input  logic               frame_we_i,
  input  logic [FRAME_W-1:0] frame_wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               idle_o,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  input  logic               mdio_i
);
  logic [FRAME_W-1:0] frame_q;
  logic busy, start, rise, fall, sample, is_read;

  assign start   = frame_we_i && !busy && mgmt_en_i;
  assign is_read = (frame_q[OP_HI:OP_LO] == OP_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  frame_q <= '0;
    else if (frame_we_i && !busy) frame_q <= frame_wdata_i;
    else if (sample)              frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], mdio_i};
  end

  mdio_clk_gen #(
    .DIV_BASE_LOG2(DIV_BASE_LOG2),
    .SEL_W        (SEL_W)
  ) i_clk_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .sel_i (clk_div_sel_i),
    .run_i (busy),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_seq #(
    .PRE_LEN(PRE_LEN),
    .FRAME_W(FRAME_W),
    .DATA_W (DATA_W),
    .TA_HI  (TA_HI)
  ) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .rise_i   (rise),
    .fall_i   (fall),
    .is_read_i(is_read),
    .frame_i  (frame_q),
    .busy_o   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .sample_o (sample)
  );

  assign frame_o = frame_q;
  assign idle_o  = !busy;
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mgmt_en_i,
  input logic [SEL_W-1:0] clk_div_sel_i,
  input logic             frame_we_i,
  input logic [31:0]      frame_wdata_i,
  input logic [31:0]      frame_o,
  input logic             idle_o,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe_o,
  input logic             mdio_i
);
  a_r1_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && mgmt_en_i && frame_we_i) |=> !idle_o);

  a_r6_mdio_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !$past(idle_o) && !$fell(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r7_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && frame_we_i) |=> (frame_o[31:16] == $past(frame_o[31:16])));

  a_r8_disabled_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !mgmt_en_i) |=> idle_o);

  a_r10_mdc_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mdc_o);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mgmt_en_i = 1'b0;
  logic [1:0]  clk_div_sel_i = 2'd0;
  logic        frame_we_i = 1'b0;
  logic [31:0] frame_wdata_i = '0;
  logic [31:0] frame_o;
  logic        idle_o, mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .mgmt_en_i(mgmt_en_i),
    .clk_div_sel_i(clk_div_sel_i), .frame_we_i(frame_we_i),
    .frame_wdata_i(frame_wdata_i), .frame_o(frame_o), .idle_o(idle_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  typedef struct {
    logic [31:0] frame;
    logic        is_rd;
    logic [15:0] rd;
    int          div;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic [15:0] phy_data = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model: presents read data after MDC falls, bits 15..0 on wire bits 48..63
  int falls = 0;
  always @(negedge idle_o) falls = 0;
  always @(negedge mdc_o) begin
    falls++;
    if (falls >= 48 && falls <= 63) mdio_i = phy_data[63-falls];
    else mdio_i = 1'b1;
  end

  // monitor, sampling between clock edges
  logic [63:0] cap_d, cap_oe;
  int busy_cyc, high_cyc, viol;
  logic p_mdc = 0, p_idle = 1, p_mdio = 1, p_oe = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (p_idle && !idle_o) begin
        busy_cyc = 0; high_cyc = 0; viol = 0; cap_d = '0; cap_oe = '0;
      end
      if (!idle_o) busy_cyc++;
      if (mdc_o) high_cyc++;
      if (mdc_o && !p_mdc) begin
        cap_d  = {cap_d[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe_o};
      end
      if ((mdio_o != p_mdio || mdio_oe_o != p_oe) && !(p_mdc && !mdc_o) && (p_idle == idle_o))
        viol++;
      if (!p_idle && idle_o) begin
        item_t it;
        logic [63:0] exp_d, exp_oe;
        logic [31:0] exp_f;
        if (q.size() == 0) check(0, "R1 unexpected transaction", 64'd1, 64'd0);
        else begin
          it = q.pop_front();
          exp_d = {32'hFFFF_FFFF, it.frame};
          for (int k = 0; k < 64; k++)
            exp_oe[63-k] = (k < 32) ? 1'b1 : !(it.is_rd && (63 - k) <= 17);
          exp_f = it.is_rd ? {it.frame[31:16], it.rd} : it.frame;
          check(cap_oe == exp_oe, "R4 R2 output enable pattern", cap_oe, exp_oe);
          check(((cap_d ^ exp_d) & exp_oe) == 0, "R2 R3 wire bits", cap_d & exp_oe, exp_d & exp_oe);
          check(busy_cyc == 64 * it.div, "R1 busy length", 64'(busy_cyc), 64'(64 * it.div));
          check(high_cyc == 32 * it.div, "R5 MDC high time", 64'(high_cyc), 64'(32 * it.div));
          check(viol == 0, "R6 MDIO change outside MDC fall", 64'(viol), 64'd0);
          check(frame_o == exp_f, "R4 R7 frame register after transaction", 64'(frame_o), 64'(exp_f));
        end
      end
    end
    p_mdc = mdc_o; p_idle = idle_o; p_mdio = mdio_o; p_oe = mdio_oe_o;
  end

  // driver
  task automatic run_xact(input logic [31:0] f, input logic [1:0] sel, input logic [15:0] rd, input bit inject);
    item_t it;
    it.frame = f; it.is_rd = (f[29:28] == 2'b10); it.rd = rd; it.div = 8 << sel;
    q.push_back(it);
    phy_data = rd;
    @(negedge clk);
    clk_div_sel_i = sel;
    frame_wdata_i = f;
    frame_we_i = 1'b1;
    @(negedge clk);
    frame_we_i = 1'b0;
    clk_div_sel_i = ~sel; // latched value must hold
    if (inject) begin
      repeat (100) @(negedge clk);
      frame_wdata_i = ~f;
      frame_we_i = 1'b1;
      @(negedge clk);
      frame_we_i = 1'b0;
    end
    while (!idle_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(frame_o == 0, "R9 frame reset", 64'(frame_o), 64'd0);
    check(idle_o == 1'b1, "R9 idle reset", 64'(idle_o), 64'd1);
    check(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R9 MDC/OE reset", {mdc_o, mdio_oe_o}, 64'd0);

    // R8 disabled write loads but does not start
    frame_wdata_i = 32'h5A2B_1234;
    frame_we_i = 1'b1;
    @(negedge clk);
    frame_we_i = 1'b0;
    begin
      bit stayed = 1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (!idle_o || mdc_o) stayed = 0;
      end
      check(stayed, "R8 no transaction when disabled", 64'(stayed), 64'd1);
      check(mdc_o == 1'b0, "R10 MDC low while idle", 64'(mdc_o), 64'd0);
    end
    check(frame_o == 32'h5A2B_1234, "R8 frame loaded when disabled", 64'(frame_o), 64'h5A2B_1234);

    mgmt_en_i = 1'b1;
    // R3 write, divisor 8
    run_xact({2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'hA5C3}, 2'd0, 16'h0000, 0);
    // R4 read, divisor 8
    run_xact({2'b01, 2'b10, 5'd17, 5'd2, 2'b10, 16'h0000}, 2'd0, 16'h9E37, 0);
    // R5 write, divisor 16
    run_xact({2'b01, 2'b01, 5'd31, 5'd0, 2'b10, 16'h0F01}, 2'd1, 16'h0000, 0);
    // R5 read, divisor 32
    run_xact({2'b01, 2'b10, 5'd1, 5'd31, 2'b10, 16'hFFFF}, 2'd2, 16'h4C8A, 0);
    // R5 write, divisor 64
    run_xact({2'b01, 2'b01, 5'd10, 5'd21, 2'b10, 16'h8001}, 2'd3, 16'h0000, 0);
    // R7 write injected during a read
    run_xact({2'b01, 2'b10, 5'd6, 5'd9, 2'b10, 16'h1111}, 2'd0, 16'hC35A, 1);

    check(q.size() == 0, "R1 every transaction completed", 64'(q.size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule